// File: doc/BRIEF.md
# Multi-Channel DMA Global Register Bank

This block is the global control and status register bank of a 64-channel DMA controller. It sits on a simple 32-bit memory-mapped bus with a write strobe, a byte address and combinational read data. It holds a control word that goes to the arbitration logic, per-channel request-enable and error-interrupt-enable vectors, per-channel interrupt and error flags, and two interrupt-routing words. Each 64-bit vector is shown to software as two 32-bit words. The high word carries channels 63..32 and the low word carries channels 31..0.

Software can change a single channel bit without a read-modify-write. It writes the channel number to a command word, and only the low byte of the write data is decoded. Command words also fire one-cycle start and done-clear strobes toward the transfer engine. The engine and arbiter are not part of this block. They show up only as input event pulses (per-channel completion flags and an error report with channel and cause) and as the output strobes. The first error reported after the status word was last cleared is frozen in that word, together with its channel and cause. A single interrupt output combines the pending flags.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and both strobe vectors are zero.
- R2: The control word (0x00) stores only bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). All other bits read zero, and the three stored bits drive `clk_gate_en_o`, `rr_group_o` and `rr_chan_o`.
- R3: Request-enable words are at 0x08 (high) and 0x0C (low). Error-interrupt-enable words are at 0x10 (high) and 0x14 (low). In a high word, bit i is channel 32+i. In a low word, bit i is channel i. A write replaces the whole word.
- R4: Command words act on the single channel named by the low data byte, from the next cycle on. 0x18 sets a request enable, 0x1C clears a request enable, 0x20 sets an error-interrupt enable and 0x24 clears an error-interrupt enable.
- R5: A command byte of 64..255 written to any command word (0x18..0x34) changes no state and fires no strobe.
- R6: A pulse on `irq_evt_i[n]` sets interrupt flag n. The flag words (0x38 high, 0x3C low) clear each bit written with a one. Command 0x28 clears one flag. An event wins over a clear in the same cycle.
- R7: `err_evt_i` sets the error flag of channel `err_chan_i`. The error words (0x40 high, 0x44 low) are write-one-to-clear. Command 0x2C clears that channel's error flag and the whole status word. An event wins over a clear in the same cycle.
- R8: The status word (0x04) captures an error event while its bit 31 is clear. The captured layout is: bit 31 set, bits 15:14 = `err_cause_i[9:8]` (group and channel priority faults), bits 13:8 = channel, bits 7:0 = `err_cause_i[7:0]`. All other bits are zero.
- R9: While status bit 31 is set, later error events set their error flags but leave the status word unchanged.
- R10: Command 0x30 drives `start_o` one-hot on the named channel for exactly the one cycle after the write. Command 0x34 does the same on `done_clr_o`.
- R11: `irq_o` is high whenever any interrupt flag is set, or any error flag is set whose error-interrupt enable is set.
- R12: The interrupt routing words 0x48 (high) and 0x4C (low) store and read back all 32 bits. Zero selects the default path.
- R13: Command words read zero. Writes to unmapped or misaligned addresses are ignored, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_evt_i | input | 64 | Per-channel completion pulses from the engine |
| err_evt_i | input | 1 | Error report pulse from the engine |
| err_chan_i | input | 6 | Channel of the reported error |
| err_cause_i | input | 10 | Cause bits: [9:8] priority faults, [7:0] transfer faults |
| start_o | output | 64 | One-cycle start strobes |
| done_clr_o | output | 64 | One-cycle done-clear strobes |
| clk_gate_en_o | output | 1 | Clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration |
| rr_chan_o | output | 1 | Round-robin channel arbitration |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions take it for granted that only one bus write happens per cycle, so a set and a clear of the same channel can never arrive together. They also assume the event inputs are single-cycle pulses that are already synchronous to `clk`. The stimulus keeps to this because every bus operation and event is driven by one task, which presents exactly one address and data pair per clock. The random phase pulses at most one completion channel and one error report per cycle. It deliberately mixes them with write-one-to-clear writes and clear commands in the same cycle, and it mixes out-of-range command bytes and unmapped addresses into the traffic.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int ADDR_W  = 8;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int NSLOT   = 1 << WIDX_W;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 10;

  typedef logic [WIDX_W-1:0] widx_t;

  // word map (byte address = index * 4)
  localparam widx_t W_CTRL    = widx_t'(0);
  localparam widx_t W_ESTAT   = widx_t'(1);
  localparam widx_t W_REQ_HI  = widx_t'(2);
  localparam widx_t W_REQ_LO  = widx_t'(3);
  localparam widx_t W_EIE_HI  = widx_t'(4);
  localparam widx_t W_EIE_LO  = widx_t'(5);
  localparam widx_t W_SREQ    = widx_t'(6);
  localparam widx_t W_CREQ    = widx_t'(7);
  localparam widx_t W_SEIE    = widx_t'(8);
  localparam widx_t W_CEIE    = widx_t'(9);
  localparam widx_t W_CINT    = widx_t'(10);
  localparam widx_t W_CERR    = widx_t'(11);
  localparam widx_t W_SSTART  = widx_t'(12);
  localparam widx_t W_CDONE   = widx_t'(13);
  localparam widx_t W_INT_HI  = widx_t'(14);
  localparam widx_t W_INT_LO  = widx_t'(15);
  localparam widx_t W_ERR_HI  = widx_t'(16);
  localparam widx_t W_ERR_LO  = widx_t'(17);
  localparam widx_t W_SEL_HI  = widx_t'(18);
  localparam widx_t W_SEL_LO  = widx_t'(19);

  localparam int CTRL_GATE   = 31;
  localparam int CTRL_RR_GRP = 3;
  localparam int CTRL_RR_CH  = 2;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << CTRL_GATE) | (DATA_W'(1) << CTRL_RR_GRP) | (DATA_W'(1) << CTRL_RR_CH);

  typedef enum logic {VEC_PLAIN, VEC_W1C} vec_kind_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dma_chan_vec.sv
module dma_chan_vec
  import dma_csr_pkg::*;
#(
  parameter int        NCH  = 64,
  parameter vec_kind_e KIND = VEC_PLAIN,
  localparam int       HALF = NCH / 2,
  localparam int       CW   = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [HALF-1:0] wdata,
  input  logic            cmd_set,
  input  logic            cmd_clr,
  input  logic [CW-1:0]   cmd_idx,
  input  logic [NCH-1:0]  hw_set,
  output logic [NCH-1:0]  q
);
  logic [NCH-1:0] q_r, after_wr, nxt;
  logic           upd;

  generate
    if (KIND == VEC_W1C) begin : g_w1c
      always_comb begin
        after_wr = q_r;
        if (wr_lo) after_wr[HALF-1:0]   = q_r[HALF-1:0] & ~wdata;
        if (wr_hi) after_wr[NCH-1:HALF] = q_r[NCH-1:HALF] & ~wdata;
      end
    end else begin : g_plain
      always_comb begin
        after_wr = q_r;
        if (wr_lo) after_wr[HALF-1:0]   = wdata;
        if (wr_hi) after_wr[NCH-1:HALF] = wdata;
      end
    end
  endgenerate

  // hardware events are merged last so they survive any clear
  always_comb begin
    nxt = after_wr;
    if (cmd_set) nxt[cmd_idx] = 1'b1;
    if (cmd_clr) nxt[cmd_idx] = 1'b0;
    nxt = nxt | hw_set;
  end

  assign upd = wr_hi | wr_lo | cmd_set | cmd_clr | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= nxt;
  end

  assign q = q_r;

  assert_cmd_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> q_r[$past(cmd_idx)]);

  // R4 (and the single-channel clears of R6/R7)
  assert_cmd_clr_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !hw_set[cmd_idx]) |=> !q_r[$past(cmd_idx)]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q_r & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_csr_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt,
  input  logic [CW-1:0]      chan,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               clr,
  output logic [DATA_W-1:0]  stat
);
  logic [DATA_W-1:0] stat_q, base, nxt;

  always_comb begin
    base = clr ? '0 : stat_q;
    nxt  = base;
    if (evt && !base[31]) begin
      nxt          = '0;
      nxt[31]      = 1'b1;
      nxt[15:14]   = cause[9:8];
      nxt[8 +: CW] = chan;
      nxt[7:0]     = cause[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= '0;
    else if (evt || clr) stat_q <= nxt;
  end

  assign stat = stat_q;

  assert_first_error_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[31] && evt && !clr) |=> $stable(stat_q));

  assert_capture_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !stat_q[31] && !clr) |=> (stat_q[31] && stat_q[8 +: CW] == $past(chan)));
endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen #(
  parameter int  NCH = 64,
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [CW-1:0]  idx,
  output logic [NCH-1:0] strobe
);
  logic [NCH-1:0] strobe_q, nxt;

  always_comb begin
    nxt = '0;
    if (fire) nxt[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= nxt;
  end

  assign strobe = strobe_q;

  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q));

  assert_strobe_hits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> strobe_q[$past(idx)]);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int  NCH  = 64,
  localparam int HALF = NCH / 2,
  localparam int CW   = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]     irq_evt_i,
  input  logic               err_evt_i,
  input  logic [CW-1:0]      err_chan_i,
  input  logic [CAUSE_W-1:0] err_cause_i,
  output logic [NCH-1:0]     start_o,
  output logic [NCH-1:0]     done_clr_o,
  output logic               clk_gate_en_o,
  output logic               rr_group_o,
  output logic               rr_chan_o,
  output logic               irq_o
);
  // HALF must equal DATA_W: each vector is split into two bus words.
  logic              rst_q;
  widx_t             widx;
  logic              hit, cmd_ok, is_cmd;
  logic [CW-1:0]     cmd_idx;
  logic [NSLOT-1:0]  wsel;
  logic [NCH-1:0]    req_q, eie_q, int_q, err_q, err_hw;
  logic [DATA_W-1:0] stat_q, ctrl_q, ctrl_nxt, sel_hi_q, sel_lo_q, rdata_c;

  dma_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_q));

  assign widx    = bus_addr[ADDR_W-1:2];
  assign hit     = bus_wr && (bus_addr[1:0] == 2'b00);
  assign cmd_ok  = (bus_wdata[7:0] < 8'(NCH));
  assign cmd_idx = bus_wdata[CW-1:0];
  assign is_cmd  = (widx >= W_SREQ) && (widx <= W_CDONE);

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
      assign wsel[g] = hit && (widx == widx_t'(g));
    end
  endgenerate

  assign err_hw = err_evt_i ? ({{(NCH-1){1'b0}}, 1'b1} << err_chan_i) : '0;

  dma_chan_vec #(.NCH(NCH), .KIND(VEC_PLAIN)) u_req (
    .clk(clk), .rst_n(rst_q), .wr_hi(wsel[W_REQ_HI]), .wr_lo(wsel[W_REQ_LO]),
    .wdata(bus_wdata), .cmd_set(wsel[W_SREQ] && cmd_ok), .cmd_clr(wsel[W_CREQ] && cmd_ok),
    .cmd_idx(cmd_idx), .hw_set('0), .q(req_q));

  dma_chan_vec #(.NCH(NCH), .KIND(VEC_PLAIN)) u_eie (
    .clk(clk), .rst_n(rst_q), .wr_hi(wsel[W_EIE_HI]), .wr_lo(wsel[W_EIE_LO]),
    .wdata(bus_wdata), .cmd_set(wsel[W_SEIE] && cmd_ok), .cmd_clr(wsel[W_CEIE] && cmd_ok),
    .cmd_idx(cmd_idx), .hw_set('0), .q(eie_q));

  dma_chan_vec #(.NCH(NCH), .KIND(VEC_W1C)) u_int (
    .clk(clk), .rst_n(rst_q), .wr_hi(wsel[W_INT_HI]), .wr_lo(wsel[W_INT_LO]),
    .wdata(bus_wdata), .cmd_set(1'b0), .cmd_clr(wsel[W_CINT] && cmd_ok),
    .cmd_idx(cmd_idx), .hw_set(irq_evt_i), .q(int_q));

  dma_chan_vec #(.NCH(NCH), .KIND(VEC_W1C)) u_err (
    .clk(clk), .rst_n(rst_q), .wr_hi(wsel[W_ERR_HI]), .wr_lo(wsel[W_ERR_LO]),
    .wdata(bus_wdata), .cmd_set(1'b0), .cmd_clr(wsel[W_CERR] && cmd_ok),
    .cmd_idx(cmd_idx), .hw_set(err_hw), .q(err_q));

  dma_err_capture #(.CW(CW)) u_estat (
    .clk(clk), .rst_n(rst_q), .evt(err_evt_i), .chan(err_chan_i), .cause(err_cause_i),
    .clr(wsel[W_CERR] && cmd_ok), .stat(stat_q));

  dma_strobe_gen #(.NCH(NCH)) u_start (
    .clk(clk), .rst_n(rst_q), .fire(wsel[W_SSTART] && cmd_ok), .idx(cmd_idx), .strobe(start_o));

  dma_strobe_gen #(.NCH(NCH)) u_done (
    .clk(clk), .rst_n(rst_q), .fire(wsel[W_CDONE] && cmd_ok), .idx(cmd_idx), .strobe(done_clr_o));

  assign ctrl_nxt = bus_wdata & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              ctrl_q <= '0;
    else if (wsel[W_CTRL])   ctrl_q <= ctrl_nxt;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              sel_hi_q <= '0;
    else if (wsel[W_SEL_HI]) sel_hi_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              sel_lo_q <= '0;
    else if (wsel[W_SEL_LO]) sel_lo_q <= bus_wdata;
  end

  always_comb begin
    rdata_c = '0;
    if (bus_addr[1:0] == 2'b00) begin
      case (widx)
        W_CTRL:   rdata_c = ctrl_q;
        W_ESTAT:  rdata_c = stat_q;
        W_REQ_HI: rdata_c = req_q[NCH-1:HALF];
        W_REQ_LO: rdata_c = req_q[HALF-1:0];
        W_EIE_HI: rdata_c = eie_q[NCH-1:HALF];
        W_EIE_LO: rdata_c = eie_q[HALF-1:0];
        W_INT_HI: rdata_c = int_q[NCH-1:HALF];
        W_INT_LO: rdata_c = int_q[HALF-1:0];
        W_ERR_HI: rdata_c = err_q[NCH-1:HALF];
        W_ERR_LO: rdata_c = err_q[HALF-1:0];
        W_SEL_HI: rdata_c = sel_hi_q;
        W_SEL_LO: rdata_c = sel_lo_q;
        default:  rdata_c = '0;
      endcase
    end
  end

  assign bus_rdata     = rdata_c;
  assign clk_gate_en_o = ctrl_q[CTRL_GATE];
  assign rr_group_o    = ctrl_q[CTRL_RR_GRP];
  assign rr_chan_o     = ctrl_q[CTRL_RR_CH];
  assign irq_o         = (|int_q) || (|(err_q & eie_q));

  assert_bad_cmd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (hit && is_cmd && !cmd_ok) |=>
      ($stable(req_q) && $stable(eie_q) && start_o == '0 && done_clr_o == '0));

  assert_irq_on_event_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (|irq_evt_i) |=> irq_o);
endmodule

// File: tb/test_dma_csr_bank.sv
module test_dma_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] irq_evt_i, start_o, done_clr_o;
  logic        err_evt_i;
  logic [5:0]  err_chan_i;
  logic [9:0]  err_cause_i;
  logic        clk_gate_en_o, rr_group_o, rr_chan_o, irq_o;

  always #5 clk = ~clk;

  dma_csr_bank i_dma_csr_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_evt_i(irq_evt_i), .err_evt_i(err_evt_i), .err_chan_i(err_chan_i),
    .err_cause_i(err_cause_i), .start_o(start_o), .done_clr_o(done_clr_o),
    .clk_gate_en_o(clk_gate_en_o), .rr_group_o(rr_group_o), .rr_chan_o(rr_chan_o), .irq_o(irq_o));

  int n_chk = 0;
  int n_bad = 0;
  bit live  = 1'b0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ctrl, m_stat, m_sel_hi, m_sel_lo;
  logic [63:0] m_req, m_eie, m_int, m_err, m_start, m_done;

  always @(posedge clk or negedge rst_n) begin : model
    logic [63:0] t_req, t_eie, t_int, t_err, t_start, t_done;
    logic [31:0] t_stat;
    int w, n;
    logic ok;
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; m_sel_hi = 0; m_sel_lo = 0;
      m_req = 0; m_eie = 0; m_int = 0; m_err = 0; m_start = 0; m_done = 0;
    end else begin
      w  = (bus_wr && bus_addr[1:0] == 2'b00) ? int'(bus_addr[7:2]) : -1;
      ok = (bus_wdata[7:0] < 8'd64);
      n  = int'(bus_wdata[5:0]);
      t_req = m_req; t_eie = m_eie; t_int = m_int; t_err = m_err;
      t_start = 0; t_done = 0; t_stat = m_stat;
      case (w)
        0:  m_ctrl = bus_wdata & 32'h8000_000C;
        2:  t_req[63:32] = bus_wdata;
        3:  t_req[31:0]  = bus_wdata;
        4:  t_eie[63:32] = bus_wdata;
        5:  t_eie[31:0]  = bus_wdata;
        6:  if (ok) t_req[n] = 1'b1;
        7:  if (ok) t_req[n] = 1'b0;
        8:  if (ok) t_eie[n] = 1'b1;
        9:  if (ok) t_eie[n] = 1'b0;
        10: if (ok) t_int[n] = 1'b0;
        11: if (ok) begin t_err[n] = 1'b0; t_stat = 0; end
        12: if (ok) t_start[n] = 1'b1;
        13: if (ok) t_done[n] = 1'b1;
        14: t_int[63:32] = t_int[63:32] & ~bus_wdata;
        15: t_int[31:0]  = t_int[31:0]  & ~bus_wdata;
        16: t_err[63:32] = t_err[63:32] & ~bus_wdata;
        17: t_err[31:0]  = t_err[31:0]  & ~bus_wdata;
        18: m_sel_hi = bus_wdata;
        19: m_sel_lo = bus_wdata;
        default: ;
      endcase
      t_int = t_int | irq_evt_i;
      if (err_evt_i) begin
        t_err[err_chan_i] = 1'b1;
        if (!t_stat[31])
          t_stat = {1'b1, 15'd0, err_cause_i[9:8], err_chan_i, err_cause_i[7:0]};
      end
      m_req = t_req; m_eie = t_eie; m_int = t_int; m_err = t_err;
      m_start = t_start; m_done = t_done; m_stat = t_stat;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (int'(a[7:2]))
      0: return m_ctrl;     1: return m_stat;
      2: return m_req[63:32]; 3: return m_req[31:0];
      4: return m_eie[63:32]; 5: return m_eie[31:0];
      14: return m_int[63:32]; 15: return m_int[31:0];
      16: return m_err[63:32]; 17: return m_err[31:0];
      18: return m_sel_hi;  19: return m_sel_lo;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(input logic [7:0] a);
    case (int'(a[7:2]))
      0: return "R2 ctrl read";
      1: return "R8 status read";
      2, 3, 4, 5: return "R3 enable read";
      14, 15: return "R6 int read";
      16, 17: return "R7 err read";
      18, 19: return "R12 route read";
      default: return "R13 command/unmapped read";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R11 irq_o", {63'd0, irq_o}, {63'd0, (|m_int) || (|(m_err & m_eie))});
      chk("R10 start_o", start_o, m_start);
      chk("R10 done_clr_o", done_clr_o, m_done);
      chk(rtag(bus_addr), {32'd0, bus_rdata}, {32'd0, mread(bus_addr)});
      chk("R2 ctrl outputs", {61'd0, clk_gate_en_o, rr_group_o, rr_chan_o},
          {61'd0, m_ctrl[31], m_ctrl[3], m_ctrl[2]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [63:0] ie, input logic ee, input logic [5:0] ec,
                      input logic [9:0] cause);
    @(posedge clk); #2;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    irq_evt_i = ie; err_evt_i = ee; err_chan_i = ec; err_cause_i = cause;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 64'd0, 1'b0, 6'd0, 10'd0);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string req);
    step(1'b0, a, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    @(negedge clk);
    chk(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic irq_expect(input logic exp, input string req);
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    @(negedge clk);
    chk(req, {63'd0, irq_o}, {63'd0, exp});
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    irq_evt_i = 64'd0; err_evt_i = 1'b0; err_chan_i = 6'd0; err_cause_i = 10'd0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step(1'b0, 8'h00, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    live = 1'b1;

    // R1 reset state
    for (int k = 0; k < 20; k++) rd_expect(8'(k * 4), 32'h0, "R1 reset value");
    chk("R1 irq_o after reset", {63'd0, irq_o}, 64'd0);
    chk("R1 start_o after reset", start_o, 64'd0);
    chk("R1 done_clr_o after reset", done_clr_o, 64'd0);

    // R2 control word
    wr(8'h00, 32'hFFFF_FFFF);
    rd_expect(8'h00, 32'h8000_000C, "R2 ctrl mask");
    chk("R2 ctrl pins", {61'd0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'd7);

    // R3 whole-word enables
    wr(8'h08, 32'hA5A5_A5A5);
    wr(8'h0C, 32'h1234_5678);
    rd_expect(8'h08, 32'hA5A5_A5A5, "R3 req high");
    rd_expect(8'h0C, 32'h1234_5678, "R3 req low");

    // R4 single-channel commands
    wr(8'h18, 32'd0);
    rd_expect(8'h0C, 32'h1234_5679, "R4 set req ch0");
    wr(8'h1C, 32'd63);
    rd_expect(8'h08, 32'h25A5_A5A5, "R4 clr req ch63");

    // R5 out-of-range command bytes
    wr(8'h18, 32'h40);
    wr(8'h1C, 32'hFF);
    wr(8'h30, 32'd200);
    rd_expect(8'h0C, 32'h1234_5679, "R5 bad set ignored");
    chk("R5 no start strobe", start_o, 64'd0);
    rd_expect(8'h08, 32'h25A5_A5A5, "R5 bad clear ignored");

    wr(8'h20, 32'd40);
    rd_expect(8'h10, 32'h0000_0100, "R4 set eie ch40");
    wr(8'h20, 32'd3);
    wr(8'h24, 32'd3);
    rd_expect(8'h14, 32'h0, "R4 set then clear eie ch3");

    // R6 interrupt flags
    step(1'b0, 8'h00, 32'd0, (64'd1 << 33) | (64'd1 << 2), 1'b0, 6'd0, 10'd0);
    rd_expect(8'h38, 32'h2, "R6 int high ch33");
    rd_expect(8'h3C, 32'h4, "R6 int low ch2");
    irq_expect(1'b1, "R11 irq from int flag");
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_expect(8'h3C, 32'h0, "R6 w1c low");
    wr(8'h28, 32'd33);
    rd_expect(8'h38, 32'h0, "R6 clear-int cmd");
    irq_expect(1'b0, "R11 irq drops");
    step(1'b1, 8'h3C, 32'hFFFF_FFFF, 64'd1 << 7, 1'b0, 6'd0, 10'd0);
    rd_expect(8'h3C, 32'h80, "R6 event beats w1c");
    wr(8'h3C, 32'h80);

    // R7 R8 R9 errors
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b1, 6'd10, 10'h205);
    rd_expect(8'h04, 32'h8000_8A05, "R8 first capture");
    rd_expect(8'h44, 32'h0000_0400, "R7 err flag ch10");
    irq_expect(1'b0, "R11 masked error");
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b1, 6'd40, 10'h0C3);
    rd_expect(8'h04, 32'h8000_8A05, "R9 status held");
    rd_expect(8'h40, 32'h0000_0100, "R9 later flag ch40");
    irq_expect(1'b1, "R11 enabled error");
    wr(8'h40, 32'h100);
    rd_expect(8'h40, 32'h0, "R7 w1c high");
    irq_expect(1'b0, "R11 error cleared");
    wr(8'h2C, 32'd10);
    rd_expect(8'h44, 32'h0, "R7 clear-err flag");
    rd_expect(8'h04, 32'h0, "R7 clear-err status");
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b1, 6'd63, 10'h1FF);
    rd_expect(8'h04, 32'h8000_7FFF, "R8 recapture ch63");
    rd_expect(8'h40, 32'h8000_0000, "R7 err flag ch63");
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h2C, 32'd63);
    rd_expect(8'h04, 32'h0, "R7 status cleared");

    // R10 strobes
    wr(8'h30, 32'd17);
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    @(negedge clk); chk("R10 start pulse", start_o, 64'd1 << 17);
    @(negedge clk); chk("R10 start one cycle", start_o, 64'd0);
    wr(8'h34, 32'd62);
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    @(negedge clk); chk("R10 done pulse", done_clr_o, 64'd1 << 62);
    @(negedge clk); chk("R10 done one cycle", done_clr_o, 64'd0);

    // R12 routing words
    wr(8'h48, 32'hDEAD_BEEF);
    wr(8'h4C, 32'h0F0F_0F0F);
    rd_expect(8'h48, 32'hDEAD_BEEF, "R12 route high");
    rd_expect(8'h4C, 32'h0F0F_0F0F, "R12 route low");

    // R13 command reads, unmapped and misaligned writes
    rd_expect(8'h18, 32'h0, "R13 command reads zero");
    wr(8'h80, 32'hFFFF_FFFF);
    rd_expect(8'h80, 32'h0, "R13 unmapped reads zero");
    wr(8'h0D, 32'h0);
    rd_expect(8'h0C, 32'h1234_5679, "R13 misaligned write ignored");

    // mixed random traffic, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      automatic int          a  = $urandom_range(0, 23);
      automatic logic [31:0] d  = $urandom;
      automatic logic [63:0] ie = 64'd0;
      automatic logic [7:0]  ad = 8'(a * 4);
      if (a >= 6 && a <= 13) d = 32'($urandom_range(0, 79));
      if ($urandom_range(0, 15) == 0) ad = ad | 8'($urandom_range(1, 3));
      if ($urandom_range(0, 3) == 0) ie = 64'd1 << $urandom_range(0, 63);
      step(1'($urandom_range(0, 1)), ad, d, ie, ($urandom_range(0, 5) == 0),
           6'($urandom_range(0, 63)), 10'($urandom_range(0, 1023)));
    end
    step(1'b0, 8'h00, 32'd0, 64'd0, 1'b0, 6'd0, 10'd0);
    @(negedge clk);
    live = 1'b0;
    summary();
    $finish;
  end
endmodule